// File: doc/BRIEF.md
# Exception Control Coprocessor

This block is the system-control coprocessor of a small 32-bit RISC core. It holds four architectural registers: a processor status word, an exception cause word, a saved return address and a faulting data address. Each is reached only by a fixed register number. The core offers exception requests together with a flag that marks the instruction boundary, which is the point where the next fetch would begin. The current instruction therefore always finishes before an exception is recognised.

When a request is accepted, the unit records the source code, the PC of the instruction that was executing and, for a bad memory access, the offending data address. It saves the mode bits and turns interrupts off. It then raises a one-cycle strobe that tells the fetch unit to go to the fixed handler entry. A return strobe from the handler puts the saved mode bits back.

The control is a three-state machine:
- ST_RUN is normal execution.
- ST_TRAP is the single redirect cycle.
- ST_HANDLER is execution inside the handler.

Its transitions are:
- ST_RUN to ST_TRAP, and ST_HANDLER to ST_TRAP, on an accepted request at a boundary.
- ST_TRAP to ST_HANDLER, always, after one cycle.
- ST_HANDLER to ST_RUN on an accepted return.

Top module: `excp_ctrl_unit`

## Requirements
- R1: After reset, Status, the Cause code, EPC and BadVaddr read 0, take_o is 0 and the machine is in ST_RUN.
- R2: A request is accepted only in a cycle with boundary_i high and the machine not in ST_TRAP. take_o is high in the cycle after acceptance, for exactly one cycle. Requests that arrive while take_o is high are dropped.
- R3: While take_o is high, redirect_o is 0x80000180. In every other cycle redirect_o equals the current EPC.
- R4: On acceptance, EPC (register 14) takes the pc_i of the accepting cycle. This capture wins over a software write to EPC in the same cycle.
- R5: On acceptance, Status bits 3:2 take the old bits 1:0, and Status bits 1:0 (bit 0 global interrupt enable, bit 1 user mode) are cleared.
- R6: The Cause code field sits in bits 6:2 (register 13). Its values are 4 for an address error, 12 for an overflow and 16 for an external interrupt, so the interrupt code is above 15.
- R7: BadVaddr (register 8) takes bad_addr_i only when an address error is accepted. At all other times it holds its value.
- R8: An interrupt is accepted only if Status bit 0 is 1 and some irq_i[k] is high with Status bit 8+k set. Cause bits 15:8 always show the live irq_i lines.
- R9: eret_i in ST_HANDLER copies Status bits 3:2 into bits 1:0 and returns to ST_RUN. eret_i in any other state has no effect.
- R10: Reads of register numbers 8, 12, 13 and 14 return those registers, and any other number reads 0. Software writes affect only Status (bits 15:8 and 3:0) and EPC. Writes to registers 8 and 13 and to any other number are ignored.
- R11: When requests arrive together, an address error wins over an overflow, and an overflow wins over an interrupt.
- R12: Writing 0x0000FFFF to Status enables every interrupt line and the global enable. Writing 0 disables them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the instruction now completing |
| boundary_i | input | 1 | Next-fetch point reached |
| ovf_i | input | 1 | Arithmetic overflow request |
| addr_err_i | input | 1 | Address error request |
| bad_addr_i | input | 32 | Faulting data address |
| irq_i | input | 8 | External interrupt lines |
| eret_i | input | 1 | Exception-return strobe |
| cp_we_i | input | 1 | Move-to-coprocessor write strobe |
| cp_idx_i | input | 5 | Register number for read and write |
| cp_wdata_i | input | 32 | Write data |
| cp_rdata_o | output | 32 | Read data for cp_idx_i |
| take_o | output | 1 | Take-exception strobe |
| redirect_o | output | 32 | Handler entry or return address |

## Verification
The hardest situations to reach from the ports are collisions inside the single ST_TRAP cycle. The stimulus sets up three of them:
- An address error at a boundary arrives exactly in the redirect cycle, and it must be dropped.
- A software write to EPC lands in the same cycle that an interrupt is accepted, and the capture must win.
- An overflow, an address error and an enabled interrupt all arrive in one boundary cycle, which exercises the priority order.

A behavioural model then compares the strobe, the redirect address and the selected register on every clock.

// File: rtl/excp_pkg.sv
package excp_pkg;
    localparam logic [4:0] IDX_BADVA  = 5'd8;
    localparam logic [4:0] IDX_STATUS = 5'd12;
    localparam logic [4:0] IDX_CAUSE  = 5'd13;
    localparam logic [4:0] IDX_EPC    = 5'd14;

    localparam logic [4:0] CODE_ADDR = 5'd4;
    localparam logic [4:0] CODE_OVF  = 5'd12;
    localparam logic [4:0] CODE_IRQ  = 5'd16;

    localparam logic [31:0] STATUS_WMASK = 32'h0000_FF0F;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_TRAP    = 2'd1,
        ST_HANDLER = 2'd2
    } xstate_e;
endpackage

// File: rtl/excp_prio.sv
module excp_prio import excp_pkg::*; #(
    parameter int NIRQ = 8
) (
    input  logic            boundary,
    input  xstate_e         state,
    input  logic            addr_err,
    input  logic            ovf,
    input  logic [NIRQ-1:0] irq,
    input  logic            gie,
    input  logic [NIRQ-1:0] imask,
    output logic            take,
    output logic [4:0]      code
);
    logic [NIRQ-1:0] hit;

    for (genvar k = 0; k < NIRQ; k++) begin : g_mask
        assign hit[k] = irq[k] & imask[k];
    end

    logic open_slot;
    logic irq_ok;

    assign open_slot = boundary && (state != ST_TRAP);
    assign irq_ok    = gie && (|hit);
    assign take      = open_slot && (addr_err || ovf || irq_ok);

    always_comb begin
        if (addr_err)  code = CODE_ADDR;
        else if (ovf)  code = CODE_OVF;
        else           code = CODE_IRQ;
    end
endmodule

// File: rtl/excp_fsm.sv
module excp_fsm import excp_pkg::*; (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    take,
    input  logic    eret,
    output xstate_e state,
    output logic    trap_cycle,
    output logic    eret_ok
);
    xstate_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (take) nxt = ST_TRAP;
            ST_TRAP:    nxt = ST_HANDLER;
            ST_HANDLER: if (take) nxt = ST_TRAP;
                        else if (eret) nxt = ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    always_comb begin
        trap_cycle = (state == ST_TRAP);
        eret_ok    = (state == ST_HANDLER) && eret && !take;
    end
endmodule

// File: rtl/excp_regs.sv
module excp_regs import excp_pkg::*; #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [4:0]      code,
    input  logic [31:0]     pc,
    input  logic [31:0]     bad_addr,
    input  logic            eret_ok,
    input  logic            we,
    input  logic [4:0]      idx,
    input  logic [31:0]     wdata,
    input  logic [NIRQ-1:0] irq,
    output logic [31:0]     rdata,
    output logic [31:0]     status,
    output logic [31:0]     cause,
    output logic [31:0]     epc,
    output logic [31:0]     badva
);
    logic [4:0]  code_q;
    logic [31:0] status_d, epc_d;

    always_comb begin
        status_d = status;
        epc_d    = epc;
        if (we && idx == IDX_STATUS) status_d = wdata & STATUS_WMASK;
        if (we && idx == IDX_EPC)    epc_d    = wdata;
        if (eret_ok)                 status_d[1:0] = status_d[3:2];
        if (take) begin
            status_d[3:2] = status_d[1:0];
            status_d[1:0] = 2'b00;
            epc_d         = pc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            epc    <= '0;
            badva  <= '0;
            code_q <= '0;
        end else begin
            status <= status_d;
            epc    <= epc_d;
            if (take) code_q <= code;
            if (take && code == CODE_ADDR) badva <= bad_addr;
        end
    end

    always_comb begin
        cause = '0;
        cause[8 +: NIRQ] = irq;
        cause[6:2] = code_q;
    end

    always_comb begin
        unique case (idx)
            IDX_BADVA:  rdata = badva;
            IDX_STATUS: rdata = status;
            IDX_CAUSE:  rdata = cause;
            IDX_EPC:    rdata = epc;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/excp_ctrl_unit.sv
module excp_ctrl_unit import excp_pkg::*; #(
    parameter int          NIRQ   = 8,
    parameter logic [31:0] VECTOR = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     pc_i,
    input  logic            boundary_i,
    input  logic            ovf_i,
    input  logic            addr_err_i,
    input  logic [31:0]     bad_addr_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            eret_i,
    input  logic            cp_we_i,
    input  logic [4:0]      cp_idx_i,
    input  logic [31:0]     cp_wdata_i,
    output logic [31:0]     cp_rdata_o,
    output logic            take_o,
    output logic [31:0]     redirect_o
);
    xstate_e     state_w;
    logic        take_w, eret_ok_w;
    logic [4:0]  code_w;
    logic [31:0] status_w, cause_w, epc_w, badva_w;

    excp_prio #(.NIRQ(NIRQ)) u_prio (
        .boundary (boundary_i),
        .state    (state_w),
        .addr_err (addr_err_i),
        .ovf      (ovf_i),
        .irq      (irq_i),
        .gie      (status_w[0]),
        .imask    (status_w[8 +: NIRQ]),
        .take     (take_w),
        .code     (code_w)
    );

    excp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take_w),
        .eret       (eret_i),
        .state      (state_w),
        .trap_cycle (take_o),
        .eret_ok    (eret_ok_w)
    );

    excp_regs #(.NIRQ(NIRQ)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take_w),
        .code     (code_w),
        .pc       (pc_i),
        .bad_addr (bad_addr_i),
        .eret_ok  (eret_ok_w),
        .we       (cp_we_i),
        .idx      (cp_idx_i),
        .wdata    (cp_wdata_i),
        .irq      (irq_i),
        .rdata    (cp_rdata_o),
        .status   (status_w),
        .cause    (cause_w),
        .epc      (epc_w),
        .badva    (badva_w)
    );

    assign redirect_o = take_o ? VECTOR : epc_w;
endmodule

// File: rtl/excp_ctrl_chk.sv
module excp_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        take_o,
    input logic [31:0] redirect_o,
    input logic [31:0] pc_i,
    input logic        addr_err_i,
    input logic        ovf_i,
    input logic [31:0] bad_addr_i,
    input logic [31:0] status_w,
    input logic [31:0] cause_w,
    input logic [31:0] epc_w,
    input logic [31:0] badva_w
);
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);
    a_r3_vector: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> redirect_o == 32'h8000_0180);
    a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> epc_w == $past(pc_i));
    a_r5_modes_off: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> status_w[1:0] == 2'b00);
    a_r11_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(addr_err_i)) |-> cause_w[6:2] == 5'd4);
    a_r8_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !$past(addr_err_i) && !$past(ovf_i)) |-> cause_w[6:2] == 5'd16);
    a_r7_badva: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(addr_err_i)) |-> badva_w == $past(bad_addr_i));
endmodule

bind excp_ctrl_unit excp_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_o     (take_o),
    .redirect_o (redirect_o),
    .pc_i       (pc_i),
    .addr_err_i (addr_err_i),
    .ovf_i      (ovf_i),
    .bad_addr_i (bad_addr_i),
    .status_w   (status_w),
    .cause_w    (cause_w),
    .epc_w      (epc_w),
    .badva_w    (badva_w)
);

// File: tb/excp_ctrl_unit_test.sv
`timescale 1ns/100ps
module excp_ctrl_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0;
    logic        boundary_i = 1'b0, ovf_i = 1'b0, addr_err_i = 1'b0;
    logic [31:0] bad_addr_i = '0;
    logic [7:0]  irq_i = '0;
    logic        eret_i = 1'b0, cp_we_i = 1'b0;
    logic [4:0]  cp_idx_i = 5'd12;
    logic [31:0] cp_wdata_i = '0;
    logic [31:0] cp_rdata_o, redirect_o;
    logic        take_o;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    excp_ctrl_unit uut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .boundary_i(boundary_i),
        .ovf_i(ovf_i), .addr_err_i(addr_err_i), .bad_addr_i(bad_addr_i),
        .irq_i(irq_i), .eret_i(eret_i), .cp_we_i(cp_we_i), .cp_idx_i(cp_idx_i),
        .cp_wdata_i(cp_wdata_i), .cp_rdata_o(cp_rdata_o), .take_o(take_o),
        .redirect_o(redirect_o)
    );

    // behavioural reference: mode 0 run, 1 redirect cycle, 2 in handler
    logic [31:0] m_status = '0, m_epc = '0, m_bva = '0;
    int          m_code = 0, m_mode = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = '0; m_epc = '0; m_bva = '0; m_code = 0; m_mode = 0;
        end else begin
            bit open, irq_hit, acc, ret;
            open    = boundary_i && (m_mode != 1);
            irq_hit = m_status[0] && ((irq_i & m_status[15:8]) != 8'h00);
            acc     = open && (addr_err_i || ovf_i || irq_hit);
            ret     = (m_mode == 2) && eret_i && !acc;
            if (cp_we_i && cp_idx_i == 5'd12) m_status = cp_wdata_i & 32'h0000_FF0F;
            if (cp_we_i && cp_idx_i == 5'd14) m_epc = cp_wdata_i;
            if (ret) m_status[1:0] = m_status[3:2];
            if (acc) begin
                m_status[3:2] = m_status[1:0];
                m_status[1:0] = 2'b00;
                m_epc = pc_i;
                if (addr_err_i) begin m_code = 4; m_bva = bad_addr_i; end
                else if (ovf_i) m_code = 12;
                else            m_code = 16;
            end
            if (acc)              m_mode = 1;
            else if (m_mode == 1) m_mode = 2;
            else if (ret)         m_mode = 0;
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] i);
        case (i)
            5'd8:    return m_bva;
            5'd12:   return m_status;
            5'd13:   return {16'h0, irq_i, 1'b0, m_code[4:0], 2'b00};
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] i);
        case (i)
            5'd8:    return "R7 badvaddr";
            5'd12:   return "R5 R9 R12 status";
            5'd13:   return "R6 R8 R11 cause";
            5'd14:   return "R4 epc";
            default: return "R10 unmapped";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        chk("R2 take strobe", {31'h0, take_o}, {31'h0, m_mode == 1});
        chk("R3 redirect", redirect_o, (m_mode == 1) ? 32'h8000_0180 : m_epc);
        chk(tag_of(cp_idx_i), cp_rdata_o, m_read(cp_idx_i));
    end

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            finish_up();
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [4:0] i, input logic [31:0] d);
        cp_we_i = 1; cp_idx_i = i; cp_wdata_i = d;
        tick();
        cp_we_i = 0;
    endtask

    task automatic ret_from_handler();
        eret_i = 1; tick(); eret_i = 0; tick();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        // R1: reset state read through the port
        chk("R1 take after reset", {31'h0, take_o}, 32'h0);
        cp_idx_i = 5'd12; #0.2 chk("R1 status", cp_rdata_o, 32'h0);
        cp_idx_i = 5'd13; #0.2 chk("R1 cause",  cp_rdata_o, 32'h0);
        cp_idx_i = 5'd14; #0.2 chk("R1 epc",    cp_rdata_o, 32'h0);
        cp_idx_i = 5'd8;  #0.2 chk("R1 badva",  cp_rdata_o, 32'h0);
        tick();

        // R12: enable everything
        wr(5'd12, 32'h0000_FFFF);
        cp_idx_i = 5'd12; tick();

        // R2/R8: interrupt without boundary is not taken, then taken at boundary
        irq_i = 8'h01; pc_i = 32'h0000_0100; tick(2);
        cp_idx_i = 5'd13; boundary_i = 1; tick(); boundary_i = 0;
        tick(2);
        // R5: inside the handler the global enable is off
        cp_idx_i = 5'd12; boundary_i = 1; pc_i = 32'h0000_0110; tick(2); boundary_i = 0;
        // R4/R10: software advances EPC by 4
        cp_idx_i = 5'd14; tick();
        wr(5'd14, 32'h0000_0104);
        cp_idx_i = 5'd12; irq_i = 8'h00;
        ret_from_handler();

        // R6/R2: overflow, then an address error dropped in the redirect cycle
        cp_idx_i = 5'd13; ovf_i = 1; boundary_i = 1; pc_i = 32'h0000_0200; tick();
        ovf_i = 0; addr_err_i = 1; bad_addr_i = 32'h1111_2222; tick();
        addr_err_i = 0; boundary_i = 0; cp_idx_i = 5'd8; tick(2);
        ret_from_handler();

        // R11/R7: all three together
        cp_idx_i = 5'd13; addr_err_i = 1; ovf_i = 1; irq_i = 8'h80; boundary_i = 1;
        bad_addr_i = 32'hDEAD_0003; pc_i = 32'h0000_0300; tick();
        addr_err_i = 0; ovf_i = 0; boundary_i = 0; irq_i = 8'h00; cp_idx_i = 5'd8; tick(2);
        ret_from_handler();
        // R11: overflow beats interrupt
        cp_idx_i = 5'd13; ovf_i = 1; irq_i = 8'h02; boundary_i = 1; pc_i = 32'h0000_0400; tick();
        ovf_i = 0; boundary_i = 0; irq_i = 8'h00; tick(2);
        ret_from_handler();

        // R10: ignored writes and unmapped numbers
        wr(5'd13, 32'hFFFF_FFFF); cp_idx_i = 5'd13; tick();
        wr(5'd8, 32'h0BAD_0BAD);  cp_idx_i = 5'd8;  tick();
        wr(5'd5, 32'h1234_5678);  cp_idx_i = 5'd5;  tick();

        // R12: writing zero blocks interrupts
        wr(5'd12, 32'h0000_0000);
        cp_idx_i = 5'd12; irq_i = 8'hFF; boundary_i = 1; pc_i = 32'h0000_0500; tick(3);
        boundary_i = 0; irq_i = 8'h00;

        // R8: line masked off by its own bit
        wr(5'd12, 32'h0000_0101);
        irq_i = 8'h02; boundary_i = 1; tick(2); boundary_i = 0;

        // R4: capture beats a same-cycle EPC write
        cp_idx_i = 5'd14; irq_i = 8'h01; boundary_i = 1; pc_i = 32'h0000_0600;
        cp_we_i = 1; cp_wdata_i = 32'h5555_5555; tick();
        cp_we_i = 0; boundary_i = 0; irq_i = 8'h00; tick(2);
        ret_from_handler();

        // R9: return strobe outside the handler has no effect
        wr(5'd12, 32'h0000_0008);
        cp_idx_i = 5'd12; eret_i = 1; tick(); eret_i = 0; tick();

        for (int i = 0; i < 16; i++) begin
            cp_idx_i = 5'(i); tick();
        end
        finish_up();
    end
endmodule